// File: doc/BRIEF.md
# Ready-Count SRAM Slave

This block connects a simple on-chip bus to an asynchronous static RAM. The master issues a command (address, read or write strobe, and write data) for one clock cycle only and never holds it. In the command cycle the slave returns no acknowledge and no wait. From the following cycle on, the slave reports a 2-bit down-counting ready count. The count tells the master how many cycles remain before read data is valid or before the write is finished.

Every signal that goes to the memory (address, chip select, output enable, write enable, write data and its drive enable) comes from a register at the pad boundary, so the memory sees a command one cycle after the bus cycle that carried it. Returned read data is captured into a register at the input boundary, and that register is the read-data output. The slave works at pipeline level 2. While the count shows 1, the master may send its next command, and the next memory access then begins in the cycle right after the current one ends.

The parameter `ACC_CYC` (2 or more) sets how many cycles the memory strobes stay active. When a command is accepted the count loads the number of cycles left, limited to 3. It then falls by one each cycle and stops at 0.

Top module: `sram_rc_slave`

## Requirements
- R1: A command is taken from a single cycle of `cmd_*`. In the next cycle `mem_addr` (and `mem_dq_out` for a write) equals the command's values. These stay unchanged for the rest of the access, even if the bus inputs change.
- R2: No response appears in the command cycle: an idle slave still shows `rdy_cnt` = 0 there. In the cycle after the command, `rdy_cnt` equals min(`ACC_CYC`, 3).
- R3: `rdy_cnt` falls by exactly 1 per cycle and stays at 0. It reaches 0 in the (`ACC_CYC`+1)-th cycle after the command cycle.
- R4: For an access, `mem_ncs_n` is low (active) for exactly `ACC_CYC` cycles, beginning in the cycle after the command. For a read, `mem_noe_n` is low over those same cycles. For a write, `mem_nwe_n` is low in all of them except the last one, and `mem_dq_oe` is 1 with the write data on `mem_dq_out`.
- R5: The value on `mem_rdata` in the last active cycle of a read is shown on `rd_data` in the first cycle where `rdy_cnt` is 0.
- R6: `rd_data` changes only when a read access completes. Writes and idle cycles leave it unchanged.
- R7: A command given while `rdy_cnt` is 1 is accepted. Its access begins in the next cycle, `mem_ncs_n` stays low with no idle cycle, and `rdy_cnt` reloads.
- R8: A command given while the count is 2 or more is ignored. The count keeps falling, the strobes and address stay as they were, and the memory is not written.
- R9: If read and write are both asserted, the command is treated as a read, and no write strobe is driven.
- R10: After reset, `rdy_cnt` = 0, `mem_ncs_n` = `mem_noe_n` = `mem_nwe_n` = 1, `mem_dq_oe` = 0 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_addr | input | ADDR_W | Command address, valid in the command cycle |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| cmd_wdata | input | DATA_W | Write data, valid in the command cycle |
| rdy_cnt | output | 2 | Cycles remaining until data is valid or the write is done |
| rd_data | output | DATA_W | Registered read data |
| mem_addr | output | ADDR_W | Registered memory address |
| mem_dq_out | output | DATA_W | Registered memory write data |
| mem_dq_oe | output | 1 | Drive enable for the memory data pins |
| mem_ncs_n | output | 1 | Memory chip select, active low |
| mem_noe_n | output | 1 | Memory output enable, active low |
| mem_nwe_n | output | 1 | Memory write enable, active low |
| mem_rdata | input | DATA_W | Data returned by the memory |

## Verification
The bench steps through a command in which the bus inputs are scrambled right after the command cycle. A slave that used the live bus inputs instead of its pad registers would drive the wrong address partway through the access. A command placed exactly at count 1 must keep chip select low with no gap and must deliver the previous read's data before the new access overwrites it; an off-by-one in the early-restart window would either insert an idle cycle or corrupt that data. A command placed at count 3 must leave the count and the memory untouched, which catches a slave that restarts or writes while it is busy. Simultaneous read and write strobes, and a write that follows a read, show whether the write path can disturb `rd_data` or the memory.

// File: rtl/sram_rc_slave.sv
module sram_rc_slave #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ACC_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [1:0]        rdy_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_ncs_n,
  output logic              mem_noe_n,
  output logic              mem_nwe_n,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int RW = $clog2(ACC_CYC + 1);

  logic [RW-1:0] rem;
  logic          op_rd;

  wire cmd_go  = cmd_rd | cmd_wr;
  wire accept  = cmd_go && (rem <= RW'(1));
  wire go_rd   = cmd_rd;
  wire go_wr   = cmd_wr & ~cmd_rd;
  wire stay    = rem > RW'(1);
  wire wr_keep = rem > RW'(2);
  wire last_rd = (rem == RW'(1)) && op_rd;

  assign rdy_cnt = (rem > RW'(3)) ? 2'd3 : rem[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem        <= '0;
      op_rd      <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      mem_ncs_n  <= 1'b1;
      mem_noe_n  <= 1'b1;
      mem_nwe_n  <= 1'b1;
      rd_data    <= '0;
    end else begin
      if (accept) begin
        rem        <= RW'(ACC_CYC);
        op_rd      <= go_rd;
        mem_addr   <= cmd_addr;
        mem_dq_out <= cmd_wdata;
      end else if (rem != '0) begin
        rem <= rem - RW'(1);
      end
      mem_ncs_n <= !(accept || stay);
      mem_noe_n <= !(accept ? go_rd : (stay && op_rd));
      mem_nwe_n <= !(accept ? go_wr : (wr_keep && !op_rd));
      mem_dq_oe <= accept ? go_wr : (stay && !op_rd);
      if (last_rd) rd_data <= mem_rdata;
    end
  end

  AST_CNT_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rdy_cnt != 2'd0); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && (rdy_cnt == 2'd1 || rdy_cnt == 2'd2)) |=> rdy_cnt == $past(rdy_cnt) - 2'd1); // R3
  AST_PAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_addr == $past(cmd_addr)); // R1
  AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_cnt == 2'd0 |-> mem_ncs_n); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_noe_n && !mem_nwe_n)); // R9
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_noe_n || !mem_nwe_n) |-> !mem_ncs_n); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_cnt != 2'd1 |=> $stable(rd_data)); // R6
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && rem > RW'(1)) |=> (rem == $past(rem) - RW'(1)) && $stable(mem_addr)); // R8
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && rdy_cnt == 2'd1) |=> !mem_ncs_n); // R7

endmodule

// File: tb/sram_rc_slave_tb.sv
module sram_rc_slave_tb_top;
  localparam int ACC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic        cmd_rd = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [1:0]  rdy_cnt;
  logic [31:0] rd_data, mem_dq_out, mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_dq_oe, mem_ncs_n, mem_noe_n, mem_nwe_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] sram [16];
  logic [31:0] last_rd = '0;

  always #10 clk = ~clk;

  sram_rc_slave #(.ADDR_W(16), .DATA_W(32), .ACC_CYC(ACC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_wdata(cmd_wdata), .rdy_cnt(rdy_cnt), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_ncs_n(mem_ncs_n),
    .mem_noe_n(mem_noe_n), .mem_nwe_n(mem_nwe_n), .mem_rdata(mem_rdata));

  assign mem_rdata = (!mem_ncs_n && !mem_noe_n) ? sram[mem_addr[3:0]] : 32'h0;
  always @(posedge clk)
    if (!mem_ncs_n && !mem_nwe_n && mem_dq_oe) sram[mem_addr[3:0]] <= mem_dq_out;

  // {is_write, addr, data or expected read value}
  localparam logic [48:0] VEC [7] = '{
    {1'b1, 16'h0005, 32'hDEAD0005},
    {1'b1, 16'h0009, 32'h12345678},
    {1'b0, 16'h0005, 32'hDEAD0005},
    {1'b0, 16'h0009, 32'h12345678},
    {1'b0, 16'h0000, 32'hA0000000},
    {1'b1, 16'h0005, 32'h0BADF00D},
    {1'b0, 16'h0005, 32'h0BADF00D}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic access(input logic is_wr, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_addr = a; cmd_rd = !is_wr; cmd_wr = is_wr; cmd_wdata = d;
    chk("R2 idle in cmd cycle", 32'(rdy_cnt), 0);
    @(negedge clk);
    cmd_rd = 0; cmd_wr = 0; cmd_addr = ~a; cmd_wdata = ~d;
    chk("R2 count after cmd", 32'(rdy_cnt), 3);
    chk("R1 pad addr", 32'(mem_addr), 32'(a));
    chk("R4 cs active", 32'(mem_ncs_n), 0);
    if (is_wr) begin
      chk("R4 we active", 32'(mem_nwe_n), 0);
      chk("R4 dq drive", 32'(mem_dq_oe), 1);
      chk("R1 pad wdata", mem_dq_out, d);
    end else chk("R4 oe active", 32'(mem_noe_n), 0);
    @(negedge clk);
    chk("R3 count 2", 32'(rdy_cnt), 2);
    @(negedge clk);
    chk("R3 count 1", 32'(rdy_cnt), 1);
    chk("R1 addr held", 32'(mem_addr), 32'(a));
    chk("R4 cs last cycle", 32'(mem_ncs_n), 0);
    if (is_wr) chk("R4 we off last cycle", 32'(mem_nwe_n), 1);
    @(negedge clk);
    chk("R3 count 0", 32'(rdy_cnt), 0);
    chk("R4 cs released", 32'(mem_ncs_n), 1);
    if (is_wr) chk("R6 rd_data kept over write", rd_data, last_rd);
    else begin
      chk("R5 read data", rd_data, d);
      last_rd = d;
    end
    @(negedge clk);
    chk("R3 count stays 0", 32'(rdy_cnt), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) sram[i] = 32'hA0000000 | i;
    #35;
    chk("R10 rdy", 32'(rdy_cnt), 0);
    chk("R10 cs", 32'(mem_ncs_n), 1);
    chk("R10 oe", 32'(mem_noe_n), 1);
    chk("R10 we", 32'(mem_nwe_n), 1);
    chk("R10 dq_oe", 32'(mem_dq_oe), 0);
    chk("R10 rd_data", rd_data, 0);
    @(negedge clk); rst_n = 1;

    for (int k = 0; k < 7; k++) access(VEC[k][48], VEC[k][47:32], VEC[k][31:0]);

    // R7: second read issued at count 1
    @(negedge clk);
    cmd_addr = 16'h0001; cmd_rd = 1;
    @(negedge clk); cmd_rd = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 window count", 32'(rdy_cnt), 1);
    cmd_addr = 16'h0002; cmd_rd = 1;
    @(negedge clk); cmd_rd = 0;
    chk("R7 reload", 32'(rdy_cnt), 3);
    chk("R7 no idle cs", 32'(mem_ncs_n), 0);
    chk("R7 new addr", 32'(mem_addr), 2);
    chk("R7 first data", rd_data, 32'hA0000001);
    @(negedge clk); @(negedge clk);
    @(negedge clk);
    chk("R7 second done", 32'(rdy_cnt), 0);
    chk("R7 second data", rd_data, 32'hA0000002);

    // R8: write at count 3 is dropped
    @(negedge clk);
    cmd_addr = 16'h0003; cmd_rd = 1;
    @(negedge clk);
    cmd_rd = 0; cmd_addr = 16'h0007; cmd_wr = 1; cmd_wdata = 32'hFFFF0000;
    @(negedge clk);
    cmd_wr = 0;
    chk("R8 count not reloaded", 32'(rdy_cnt), 2);
    chk("R8 addr kept", 32'(mem_addr), 3);
    chk("R8 no write strobe", 32'(mem_nwe_n), 1);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R8 count idle", 32'(rdy_cnt), 0);
    last_rd = 32'hA0000003;
    access(1'b0, 16'h0007, 32'hA0000007);

    // R9: read and write together act as read
    @(negedge clk);
    cmd_addr = 16'h0004; cmd_rd = 1; cmd_wr = 1; cmd_wdata = 32'h55555555;
    @(negedge clk);
    cmd_rd = 0; cmd_wr = 0;
    chk("R9 oe active", 32'(mem_noe_n), 0);
    chk("R9 no we", 32'(mem_nwe_n), 1);
    chk("R9 no drive", 32'(mem_dq_oe), 0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R9 read result", rd_data, 32'hA0000004);
    last_rd = 32'hA0000004;
    access(1'b0, 16'h0004, 32'hA0000004);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule